// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block is the digital control core of a 1024-position digitally controlled potentiometer. A volatile 10-bit wiper position register drives a 1024-bit one-hot tap-select bus. Each bit of that bus closes one switch along the resistor string. A bank of four 10-bit storage registers stands in for the non-volatile memory. These hold saved wiper positions, or any other values the host wants to keep.

The host issues single-cycle commands on a parallel port: an opcode, a bank index and a write value. The block reads and writes the wiper and the bank. It copies a bank entry into the wiper, or the wiper into a bank entry, and it reports a busy status. Any change to the bank starts a timed busy window that models the slow non-volatile write. A synchronous reset stands for a power cycle. It reloads the wiper from bank entry 0 and leaves the bank untouched. It then holds off read commands and write commands for two separate lockout windows. A command that cannot run is dropped and answered with a one-cycle reject pulse.

Top module: `dpot_ctrl`

## Requirements
- R1: On reset (rst_n low at a clock edge) the wiper takes the value of bank entry 0, while `rd_valid`, `cmd_reject` and `wip` go low; bank contents are kept across reset.
- R2: Opcode 2 (write wiper), once accepted, loads `cmd_wdata` into the wiper.
- R3: Opcode 1 (read wiper), once accepted, returns the wiper value on `rd_data` with `rd_valid` high for one cycle, in the cycle after the command.
- R4: Opcode 4 (write bank) stores `cmd_wdata` into entry `cmd_sel`. Opcode 3 (read bank) returns entry `cmd_sel` one cycle later with `rd_valid`.
- R5: Opcode 5 (bank to wiper) loads the wiper from entry `cmd_sel`.
- R6: Opcode 6 (wiper to bank) stores the current wiper value into entry `cmd_sel`.
- R7: Opcodes 4 and 6 set `wip` for exactly NV_WR_CYC cycles, starting in the cycle after acceptance. Opcode 7 (read status) returns `wip` in bit 0 of `rd_data`, with all other bits zero.
- R8: While `wip` is high, opcodes 3, 4, 5 and 6 are rejected and have no effect. Opcodes 1, 2 and 7 are still accepted.
- R9: Read opcodes (1, 3, 7) are rejected until RD_LOCK_CYC cycles have passed since reset was released.
- R10: Write opcodes (2, 4, 5, 6) are rejected, with no effect, until WR_LOCK_CYC cycles have passed since reset was released.
- R11: `tap_sel` has exactly one bit set, at index equal to the wiper value, and it follows a wiper change one cycle later.
- R12: A rejected command raises `cmd_reject` for one cycle, in the cycle after the command, with no `rd_valid`. Opcode 0 is a no-op and is neither accepted nor rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; models a power cycle |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode 0..7 |
| cmd_sel | input | 2 | Bank entry index |
| cmd_wdata | input | 10 | Write value |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 10 | Read result |
| cmd_reject | output | 1 | Command dropped pulse |
| wip | output | 1 | Non-volatile write busy |
| wiper_pos | output | 10 | Current wiper position |
| tap_sel | output | 1024 | One-hot tap switch enables |

## Verification
The command port is sampled at a clock edge. `rd_valid`, `rd_data`, `cmd_reject`, `wiper_pos` and the rise of `wip` are due one edge later, and `tap_sel` one edge after the wiper. The bench drives every command on a falling edge. It samples the registered responses on the next falling edge, and it checks `tap_sel` one falling edge after that. The busy length is measured by counting falling edges with `wip` high. The lockout checks place commands well inside or well past each window, counted in edges from reset release.

// File: rtl/dpot_pkg.sv
// Shared opcode encoding for the potentiometer controller.
package dpot_pkg;
    typedef enum logic [2:0] {
        OP_NOP           = 3'd0,
        OP_RD_WIPER      = 3'd1,
        OP_WR_WIPER      = 3'd2,
        OP_RD_BANK       = 3'd3,
        OP_WR_BANK       = 3'd4,
        OP_BANK_TO_WIPER = 3'd5,
        OP_WIPER_TO_BANK = 3'd6,
        OP_RD_STATUS     = 3'd7
    } op_e;
endpackage

// File: rtl/dpot_lockout.sv
// Power-up lockout: counts cycles since reset release and opens the read
// window after RD_LOCK_CYC and the write window after WR_LOCK_CYC.
// Assumes WR_LOCK_CYC >= RD_LOCK_CYC.
module dpot_lockout #(
    parameter int RD_LOCK_CYC = 100,
    parameter int WR_LOCK_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic rd_ok_o,
    output logic wr_ok_o
);
    localparam int CW = $clog2(WR_LOCK_CYC + 2);

    logic [CW-1:0] age_q;

    // Saturating age counter since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)                        age_q <= '0;
        else if (32'(age_q) < WR_LOCK_CYC) age_q <= age_q + 1'b1;
    end

    assign rd_ok_o = (32'(age_q) >= RD_LOCK_CYC);
    assign wr_ok_o = (32'(age_q) >= WR_LOCK_CYC);

    // R10
    wr_implies_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok_o |-> rd_ok_o);
    // R9
    rd_window_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok_o |=> rd_ok_o);
endmodule

// File: rtl/dpot_nvtimer.sv
// Non-volatile write busy timer: after a start pulse, busy_o is high for
// exactly NV_WR_CYC cycles. Assumes no start while busy.
module dpot_nvtimer #(
    parameter int NV_WR_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(NV_WR_CYC + 1);

    logic [CW-1:0] left_q;
    logic          busy_q;

    // Load the busy window on start, count down, drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            left_q <= CW'(NV_WR_CYC - 1);
        end else if (busy_q) begin
            if (left_q == '0) busy_q <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    assign busy_o = busy_q;

    // R7
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i);
endmodule

// File: rtl/dpot_tapdec.sv
// Registered one-hot decode of the wiper position onto the tap switches.
// Assumes reset is held long enough for the wiper to be defined.
module dpot_tapdec #(
    parameter int NUM_TAPS = 1024,
    localparam int PW      = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PW-1:0]       wiper_i,
    output logic [NUM_TAPS-1:0] tap_o
);
    logic [NUM_TAPS-1:0] hit;
    logic [NUM_TAPS-1:0] tap_q;

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign hit[t] = (wiper_i == PW'(t));
    end

    // Register the decode so switches change one cycle after the wiper.
    always_ff @(posedge clk) begin
        tap_q <= hit;
    end

    assign tap_o = tap_q;

    // R11
    tap_follows_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o == (NUM_TAPS'(1) << $past(wiper_i)));
    // R11
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_o) == 1);
endmodule

// File: rtl/dpot_ctrl.sv
// Potentiometer control core: command decode, volatile wiper, bank of
// storage registers that survive reset, busy timer, power-up lockout and
// tap decode. The bank keeps its contents across rst_n (non-volatile model).
module dpot_ctrl #(
    parameter int NUM_TAPS    = 1024,
    parameter int NUM_BANKS   = 4,
    parameter int BANK_INIT   = 0,
    parameter int NV_WR_CYC   = 10000,
    parameter int RD_LOCK_CYC = 100,
    parameter int WR_LOCK_CYC = 5000,
    localparam int PW         = $clog2(NUM_TAPS),
    localparam int SW         = $clog2(NUM_BANKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [SW-1:0]       cmd_sel,
    input  logic [PW-1:0]       cmd_wdata,
    output logic                rd_valid,
    output logic [PW-1:0]       rd_data,
    output logic                cmd_reject,
    output logic                wip,
    output logic [PW-1:0]       wiper_pos,
    output logic [NUM_TAPS-1:0] tap_sel
);
    import dpot_pkg::*;

    op_e         op;
    logic        rd_ok, wr_ok;
    logic        is_rd, is_wr, needs_idle, allowed, accept, nv_start;
    logic [PW-1:0] wiper_q, rdat_d;
    logic        rvalid_q, rej_q;
    logic [PW-1:0] rdata_q;
    logic [PW-1:0] bank_q [NUM_BANKS] = '{default: PW'(BANK_INIT)};

    dpot_lockout #(.RD_LOCK_CYC(RD_LOCK_CYC), .WR_LOCK_CYC(WR_LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok));

    dpot_nvtimer #(.NV_WR_CYC(NV_WR_CYC)) u_nv (
        .clk(clk), .rst_n(rst_n), .start_i(nv_start), .busy_o(wip));

    dpot_tapdec #(.NUM_TAPS(NUM_TAPS)) u_dec (
        .clk(clk), .rst_n(rst_n), .wiper_i(wiper_q), .tap_o(tap_sel));

    // Classify the opcode and decide whether the command may run now.
    always_comb begin
        op         = op_e'(cmd_op);
        is_rd      = (op == OP_RD_WIPER) || (op == OP_RD_BANK) || (op == OP_RD_STATUS);
        is_wr      = (op != OP_NOP) && !is_rd;
        needs_idle = (op == OP_RD_BANK) || (op == OP_WR_BANK) ||
                     (op == OP_BANK_TO_WIPER) || (op == OP_WIPER_TO_BANK);
        allowed    = ((is_rd && rd_ok) || (is_wr && wr_ok)) && !(needs_idle && wip);
        accept     = cmd_valid && (op != OP_NOP) && allowed;
        nv_start   = accept && ((op == OP_WR_BANK) || (op == OP_WIPER_TO_BANK));
        case (op)
            OP_RD_BANK:   rdat_d = bank_q[cmd_sel];
            OP_RD_STATUS: rdat_d = PW'(wip);
            default:      rdat_d = wiper_q;
        endcase
    end

    // Bank storage: written only by accepted bank-modifying commands.
    always_ff @(posedge clk) begin
        if (rst_n && nv_start)
            bank_q[cmd_sel] <= (op == OP_WR_BANK) ? cmd_wdata : wiper_q;
    end

    // Wiper register with power-up recall of bank entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wiper_q <= bank_q[0];
        else if (accept && op == OP_WR_WIPER)
            wiper_q <= cmd_wdata;
        else if (accept && op == OP_BANK_TO_WIPER)
            wiper_q <= bank_q[cmd_sel];
    end

    // Response registers: read strobe, read data and reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rej_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= accept && is_rd;
            rej_q    <= cmd_valid && (op != OP_NOP) && !allowed;
            if (accept && is_rd) rdata_q <= rdat_d;
        end
    end

    assign rd_valid   = rvalid_q;
    assign rd_data    = rdata_q;
    assign cmd_reject = rej_q;
    assign wiper_pos  = wiper_q;

    // R12
    excl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && cmd_reject));
    // R8
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && cmd_valid && cmd_op == 3'd4) |=> cmd_reject);
    // R2
    wr_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2) |=> (cmd_reject || wiper_pos == $past(cmd_wdata)));
    // R12
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> !rd_valid && !$past(cmd_op == 3'd0));
endmodule

// File: tb/dpot_ctrl_tb.sv
module dpot_ctrl_tb;
    localparam int NV = 20;
    localparam int RDL = 6;
    localparam int WRL = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_sel = '0;
    logic [9:0]  cmd_wdata = '0;
    logic        rd_valid, cmd_reject, wip;
    logic [9:0]  rd_data, wiper_pos;
    logic [1023:0] tap_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dpot_ctrl #(.BANK_INIT(5), .NV_WR_CYC(NV), .RD_LOCK_CYC(RDL), .WR_LOCK_CYC(WRL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .cmd_reject(cmd_reject), .wip(wip),
        .wiper_pos(wiper_pos), .tap_sel(tap_sel));

    // vector: op, sel, wdata, exp_reject, exp_rvalid, exp_rdata, exp_wiper
    typedef struct packed {
        logic [2:0] op; logic [1:0] sel; logic [9:0] wd;
        logic rej; logic rv; logic [9:0] rd; logic [9:0] wp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{3'd2, 2'd0, 10'd700,  1'b0, 1'b0, 10'd0,    10'd700},
        '{3'd1, 2'd0, 10'd0,    1'b0, 1'b1, 10'd700,  10'd700},
        '{3'd4, 2'd2, 10'd123,  1'b0, 1'b0, 10'd0,    10'd700},
        '{3'd3, 2'd2, 10'd0,    1'b0, 1'b1, 10'd123,  10'd700},
        '{3'd4, 2'd1, 10'd1023, 1'b0, 1'b0, 10'd0,    10'd700},
        '{3'd3, 2'd1, 10'd0,    1'b0, 1'b1, 10'd1023, 10'd700},
        '{3'd5, 2'd1, 10'd0,    1'b0, 1'b0, 10'd0,    10'd1023},
        '{3'd2, 2'd0, 10'd0,    1'b0, 1'b0, 10'd0,    10'd0},
        '{3'd6, 2'd3, 10'd0,    1'b0, 1'b0, 10'd0,    10'd0},
        '{3'd3, 2'd3, 10'd0,    1'b0, 1'b1, 10'd0,    10'd0},
        '{3'd5, 2'd2, 10'd0,    1'b0, 1'b0, 10'd0,    10'd123},
        '{3'd6, 2'd0, 10'd0,    1'b0, 1'b0, 10'd0,    10'd123},
        '{3'd0, 2'd0, 10'd9,    1'b0, 1'b0, 10'd0,    10'd123},
        '{3'd7, 2'd0, 10'd0,    1'b0, 1'b1, 10'd0,    10'd123}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one command for one edge; returns with that edge's results visible.
    task automatic issue(input logic [2:0] op, input logic [1:0] sel, input logic [9:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        int busy_len;
        do_reset();
        // R1: recall of bank entry 0 (initial value 5), responses low
        chk(wiper_pos == 10'd5, "R1 recall", wiper_pos, 5);
        chk(!rd_valid && !cmd_reject && !wip, "R1 outputs low",
            {rd_valid, cmd_reject, wip}, 0);
        // R9 / R10: inside lockout windows
        issue(3'd1, 2'd0, 10'd0);
        chk(cmd_reject && !rd_valid, "R9 early read rejected", cmd_reject, 1);
        issue(3'd2, 2'd0, 10'd44);
        chk(cmd_reject, "R10 early write rejected", cmd_reject, 1);
        chk(wiper_pos == 10'd5, "R10 early write no effect", wiper_pos, 5);
        idle(RDL + 2);
        issue(3'd1, 2'd0, 10'd0);
        chk(rd_valid && rd_data == 10'd5, "R9 R3 read after window", rd_data, 5);
        issue(3'd2, 2'd0, 10'd44);
        chk(cmd_reject && wiper_pos == 10'd5, "R10 write still locked", wiper_pos, 5);
        // R11: tap bus at the recalled position
        chk(tap_sel == (1024'(1) << 5), "R11 tap after recall", $countones(tap_sel), 1);
        idle(WRL);

        // Table walk: R2 R3 R4 R5 R6 R7 R11 R12
        for (int v = 0; v < NVEC; v++) begin
            issue(VECS[v].op, VECS[v].sel, VECS[v].wd);
            chk(cmd_reject == VECS[v].rej, "R12 reject", cmd_reject, VECS[v].rej);
            chk(rd_valid == VECS[v].rv, "R3 R4 rd_valid", rd_valid, VECS[v].rv);
            if (VECS[v].rv)
                chk(rd_data == VECS[v].rd, "R3 R4 R7 rd_data", rd_data, VECS[v].rd);
            chk(wiper_pos == VECS[v].wp, "R2 R5 wiper", wiper_pos, VECS[v].wp);
            @(negedge clk);
            chk(tap_sel == (1024'(1) << VECS[v].wp), "R11 tap follows", $countones(tap_sel), 1);
            if (VECS[v].op == 3'd4 || VECS[v].op == 3'd6) idle(NV + 2);
        end

        // R7 / R8: behaviour while busy
        issue(3'd4, 2'd0, 10'd77);
        chk(wip, "R7 busy after write", wip, 1);
        issue(3'd7, 2'd0, 10'd0);
        chk(rd_valid && rd_data == 10'd1, "R7 R8 status while busy", rd_data, 1);
        issue(3'd4, 2'd1, 10'd5);
        chk(cmd_reject && !rd_valid, "R8 write bank rejected", cmd_reject, 1);
        issue(3'd3, 2'd1, 10'd0);
        chk(cmd_reject && !rd_valid, "R8 read bank rejected", cmd_reject, 1);
        issue(3'd5, 2'd1, 10'd0);
        chk(cmd_reject && wiper_pos == 10'd123, "R8 transfer rejected", wiper_pos, 123);
        issue(3'd2, 2'd0, 10'd9);
        chk(!cmd_reject && wiper_pos == 10'd9, "R8 wiper write allowed", wiper_pos, 9);
        issue(3'd1, 2'd0, 10'd0);
        chk(rd_valid && rd_data == 10'd9, "R8 wiper read allowed", rd_data, 9);
        idle(NV + 2);
        chk(!wip, "R7 busy ends", wip, 0);
        issue(3'd3, 2'd1, 10'd0);
        chk(rd_valid && rd_data == 10'd1023, "R8 rejected write no effect", rd_data, 1023);

        // R7: busy length
        issue(3'd6, 2'd3, 10'd0);
        busy_len = 0;
        while (wip && busy_len < 1000) begin
            busy_len++;
            @(negedge clk);
        end
        chk(busy_len == NV, "R7 busy length", busy_len, NV);
        issue(3'd3, 2'd3, 10'd0);
        chk(rd_valid && rd_data == 10'd9, "R6 wiper to bank", rd_data, 9);

        // R1: power cycle during busy write
        issue(3'd4, 2'd2, 10'd456);
        do_reset();
        chk(wiper_pos == 10'd77, "R1 recall after cycle", wiper_pos, 77);
        chk(!wip && !rd_valid && !cmd_reject, "R1 busy cleared", wip, 0);
        idle(WRL + 2);
        issue(3'd3, 2'd2, 10'd0);
        chk(rd_valid && rd_data == 10'd456, "R1 bank kept", rd_data, 456);
        issue(3'd0, 2'd0, 10'd3);
        chk(!rd_valid && !cmd_reject && wiper_pos == 10'd77, "R12 nop ignored", wiper_pos, 77);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule